// File: doc/BRIEF.md
# Secure Monitor Vector Base Register

This block holds the base address of the vector table used when the processor enters secure monitor mode, together with the access checks that guard it and the adder that turns an exception into a branch target. Software reaches the register through a coprocessor transfer port. The port carries a strobe, a read/write direction, four selector fields and write data. The block decides from the current security world, the privilege level and a secure write-disable input whether the transfer is allowed. A disallowed transfer raises a one-cycle undefined-instruction flag and changes nothing.

In parallel, the exception logic presents each exception with a type code and three route-to-monitor configuration bits. A secure monitor call always goes to monitor mode. IRQ, FIQ and external aborts go there only when their own route bit is set. For each exception that goes to monitor mode, the block produces the stored base plus that exception's fixed offset and flags the result valid. For every other exception it keeps the valid flag low, so the normal vector logic handles it. All outputs are registered and appear one clock after the cycle that caused them.

Top module: `mon_vec_base`

## Requirements
- R1: After a synchronous reset the stored base is 0x00000000. The outputs rd_valid, undef_flag and tgt_valid are low, and rd_data and tgt_addr are zero.
- R2: A transfer addresses this register only when op1=0, crn=12, crm=0 and op2=1, for both reads and writes. Any other encoding raises no flag, returns no data and leaves the base unchanged.
- R3: A read from the secure privileged state (ns_state=0, priv=1) gives rd_valid=1 and rd_data equal to the stored base, one cycle after the strobe. In all other cycles rd_valid=0 and rd_data=0.
- R4: A write from the secure privileged state with wr_lock=0 stores wdata bits [31:5]. Bits [4:0] always read back as zero, whatever was written.
- R5: Any addressed transfer from the non-secure privileged state (ns_state=1, priv=1), read or write, raises undef_flag. It returns no data and leaves the base unchanged.
- R6: Any addressed transfer from user level (priv=0) raises undef_flag in either world. It returns no data and leaves the base unchanged.
- R7: A secure privileged write while wr_lock=1 raises undef_flag and leaves the base unchanged. A secure privileged read while wr_lock=1 succeeds normally.
- R8: undef_flag is high for exactly the one cycle after each refused strobe. The base never changes across a cycle in which undef_flag is raised.
- R9: Exception type codes are 0 = secure monitor call, 1 = prefetch external abort, 2 = data external abort, 3 = IRQ, 4 = FIQ, and 5 to 7 = other. The offsets are 0x08, 0x0C, 0x10, 0x18 and 0x1C respectively. A secure monitor call always gives tgt_valid=1 and tgt_addr = base + 0x08, one cycle after exc_valid.
- R10: Types 1 and 2 use the monitor base only when route_abt=1, type 3 only when route_irq=1, and type 4 only when route_fiq=1. Types 5 to 7 never use it. An exception that does not use it gives tgt_valid=0 and tgt_addr=0.
- R11: When an exception and an accepted write fall in the same cycle, the target uses the base held before that write. The new base applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Coprocessor transfer strobe |
| acc_write | input | 1 | 1 = write transfer, 0 = read transfer |
| acc_op1 | input | 3 | First opcode selector field |
| acc_crn | input | 4 | Primary register selector |
| acc_crm | input | 4 | Secondary register selector |
| acc_op2 | input | 3 | Second opcode selector field |
| acc_wdata | input | 32 | Write data |
| ns_state | input | 1 | 1 = non-secure world, 0 = secure world |
| priv | input | 1 | 1 = privileged level, 0 = user level |
| wr_lock | input | 1 | Secure write-disable |
| exc_valid | input | 1 | Exception presented this cycle |
| exc_type | input | 3 | Exception type code |
| route_irq | input | 1 | Route IRQ to monitor mode |
| route_fiq | input | 1 | Route FIQ to monitor mode |
| route_abt | input | 1 | Route external aborts to monitor mode |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| undef_flag | output | 1 | Undefined-instruction pulse for a refused transfer |
| tgt_valid | output | 1 | Monitor branch target valid |
| tgt_addr | output | 32 | Monitor branch target |

## Verification
The hardest case to reach from the ports is an accepted write that lands in the same cycle as a routed exception. Only here can the ordering between storing the base and reading it for the target be seen. The bench steers a write with a new base and a secure monitor call into the same cycle, then repeats the call on the next cycle to show the switch-over. It also runs a long pseudo-random mix of worlds, privilege levels, lock states, encodings and route bits. This mix drives the same collision by chance against a behavioural model that is checked every clock.

// File: rtl/mvb_pkg.sv
package mvb_pkg;

  localparam int XT_W = 3;

  typedef enum logic [XT_W-1:0] {
    XK_SMC  = 3'd0,
    XK_PABT = 3'd1,
    XK_DABT = 3'd2,
    XK_IRQ  = 3'd3,
    XK_FIQ  = 3'd4
  } exc_kind_e;

  typedef struct packed {
    logic hit;
    logic rd_ok;
    logic wr_ok;
    logic deny;
  } acc_verdict_t;

  function automatic logic [5:0] vec_offset(input logic [XT_W-1:0] kind);
    case (kind)
      XK_SMC:  vec_offset = 6'h08;
      XK_PABT: vec_offset = 6'h0C;
      XK_DABT: vec_offset = 6'h10;
      XK_IRQ:  vec_offset = 6'h18;
      XK_FIQ:  vec_offset = 6'h1C;
      default: vec_offset = 6'h00;
    endcase
  endfunction

endpackage

// File: rtl/mvb_access_chk.sv
module mvb_access_chk
  import mvb_pkg::*;
#(
  parameter int OP1_W   = 3,
  parameter int CR_W    = 4,
  parameter int OP2_W   = 3,
  parameter int SEL_OP1 = 0,
  parameter int SEL_CRN = 12,
  parameter int SEL_CRM = 0,
  parameter int SEL_OP2 = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [OP1_W-1:0] acc_op1,
  input  logic [CR_W-1:0]  acc_crn,
  input  logic [CR_W-1:0]  acc_crm,
  input  logic [OP2_W-1:0] acc_op2,
  input  logic             ns_state,
  input  logic             priv,
  input  logic             wr_lock,
  output acc_verdict_t     verdict
);

  logic enc_match;
  logic secure_priv;

  always_comb begin
    enc_match = (acc_op1 == OP1_W'(SEL_OP1)) &&
                (acc_crn == CR_W'(SEL_CRN))  &&
                (acc_crm == CR_W'(SEL_CRM))  &&
                (acc_op2 == OP2_W'(SEL_OP2));
    secure_priv   = !ns_state && priv;
    verdict.hit   = acc_valid && enc_match;
    verdict.rd_ok = verdict.hit && secure_priv && !acc_write;
    verdict.wr_ok = verdict.hit && secure_priv && acc_write && !wr_lock;
    verdict.deny  = verdict.hit && !(verdict.rd_ok || verdict.wr_ok);
  end

  AST_NS_DENY: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && enc_match && ns_state) |-> verdict.deny);             // R5
  AST_USER_DENY: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && enc_match && !priv) |-> verdict.deny);                // R6
  AST_LOCK_NOWR: assert property (@(posedge clk) disable iff (rst)
    wr_lock |-> !verdict.wr_ok);                                         // R7
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enc_match |-> !(verdict.deny || verdict.rd_ok || verdict.wr_ok));   // R2

endmodule

// File: rtl/mvb_base_reg.sv
module mvb_base_reg
  import mvb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOW_ZERO = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_verdict_t      verdict,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              undef_flag
);

  localparam int HI_W = ADDR_W - LOW_ZERO;

  logic [HI_W-1:0] base_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi <= '0;
    end else if (verdict.wr_ok) begin
      base_hi <= acc_wdata[ADDR_W-1:LOW_ZERO];
    end
  end

  generate
    if (LOW_ZERO > 0) begin : g_low
      assign base = {base_hi, {LOW_ZERO{1'b0}}};
    end else begin : g_full
      assign base = base_hi;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      undef_flag <= 1'b0;
    end else begin
      rd_data    <= verdict.rd_ok ? base : '0;
      rd_valid   <= verdict.rd_ok;
      undef_flag <= verdict.deny;
    end
  end

  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    undef_flag |-> (base == $past(base)));                               // R8
  AST_UNDEF_SRC: assert property (@(posedge clk) disable iff (rst)
    undef_flag |-> $past(verdict.deny));                                 // R8
  AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[LOW_ZERO-1:0] == '0));                         // R4
  AST_RD_UNDEF_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && undef_flag));                                          // R3

endmodule

// File: rtl/mvb_vec_gen.sv
module mvb_vec_gen
  import mvb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic              exc_valid,
  input  logic [XT_W-1:0]   exc_type,
  input  logic              route_irq,
  input  logic              route_fiq,
  input  logic              route_abt,
  output logic              tgt_valid,
  output logic [ADDR_W-1:0] tgt_addr
);

  logic to_monitor;

  always_comb begin
    case (exc_type)
      XK_SMC:          to_monitor = 1'b1;
      XK_PABT, XK_DABT: to_monitor = route_abt;
      XK_IRQ:          to_monitor = route_irq;
      XK_FIQ:          to_monitor = route_fiq;
      default:         to_monitor = 1'b0;
    endcase
    to_monitor = to_monitor && exc_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid <= 1'b0;
      tgt_addr  <= '0;
    end else begin
      tgt_valid <= to_monitor;
      tgt_addr  <= to_monitor ? (base + ADDR_W'(vec_offset(exc_type))) : '0;
    end
  end

  AST_TGT_SRC: assert property (@(posedge clk) disable iff (rst)
    tgt_valid |-> $past(exc_valid));                                     // R9
  AST_NO_OTHER: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && (exc_type > 3'd4)) |=> !tgt_valid);                    // R10
  AST_SMC_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && (exc_type == 3'd0)) |=> tgt_valid);                    // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !tgt_valid |-> (tgt_addr == '0));                                    // R10

endmodule

// File: rtl/mon_vec_base.sv
module mon_vec_base
  import mvb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOW_ZERO = 5,
  parameter int OP1_W    = 3,
  parameter int CR_W     = 4,
  parameter int OP2_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [OP1_W-1:0]  acc_op1,
  input  logic [CR_W-1:0]   acc_crn,
  input  logic [CR_W-1:0]   acc_crm,
  input  logic [OP2_W-1:0]  acc_op2,
  input  logic [ADDR_W-1:0] acc_wdata,
  input  logic              ns_state,
  input  logic              priv,
  input  logic              wr_lock,
  input  logic              exc_valid,
  input  logic [2:0]        exc_type,
  input  logic              route_irq,
  input  logic              route_fiq,
  input  logic              route_abt,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              undef_flag,
  output logic              tgt_valid,
  output logic [ADDR_W-1:0] tgt_addr
);

  acc_verdict_t      verdict;
  logic [ADDR_W-1:0] base;

  mvb_access_chk #(
    .OP1_W(OP1_W), .CR_W(CR_W), .OP2_W(OP2_W),
    .SEL_OP1(0), .SEL_CRN(12), .SEL_CRM(0), .SEL_OP2(1)
  ) u_chk (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .ns_state(ns_state), .priv(priv), .wr_lock(wr_lock),
    .verdict(verdict)
  );

  mvb_base_reg #(.ADDR_W(ADDR_W), .LOW_ZERO(LOW_ZERO)) u_reg (
    .clk(clk), .rst(rst), .verdict(verdict), .acc_wdata(acc_wdata),
    .base(base), .rd_data(rd_data), .rd_valid(rd_valid), .undef_flag(undef_flag)
  );

  mvb_vec_gen #(.ADDR_W(ADDR_W)) u_vec (
    .clk(clk), .rst(rst), .base(base),
    .exc_valid(exc_valid), .exc_type(exc_type),
    .route_irq(route_irq), .route_fiq(route_fiq), .route_abt(route_abt),
    .tgt_valid(tgt_valid), .tgt_addr(tgt_addr)
  );

  AST_REFUSED_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ns_state) |=> !rd_valid);                              // R5
  AST_UNDEF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (undef_flag && !$past(acc_valid, 1)) |-> 1'b0);                      // R8

endmodule

// File: tb/mon_vec_base_tb.sv
`timescale 1ns/1ps
module mon_vec_base_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [2:0]  acc_op1, acc_op2;
  logic [3:0]  acc_crn, acc_crm;
  logic [31:0] acc_wdata;
  logic        ns_state, priv, wr_lock;
  logic        exc_valid;
  logic [2:0]  exc_type;
  logic        route_irq, route_fiq, route_abt;
  logic [31:0] rd_data, tgt_addr;
  logic        rd_valid, undef_flag, tgt_valid;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int unsigned ref_base = 0;
  logic [31:0] lf = 32'h1234_5679;

  always #4 clk = ~clk;

  mon_vec_base u_dut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_wdata(acc_wdata), .ns_state(ns_state), .priv(priv), .wr_lock(wr_lock),
    .exc_valid(exc_valid), .exc_type(exc_type),
    .route_irq(route_irq), .route_fiq(route_fiq), .route_abt(route_abt),
    .rd_data(rd_data), .rd_valid(rd_valid), .undef_flag(undef_flag),
    .tgt_valid(tgt_valid), .tgt_addr(tgt_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 0; acc_write = 0; acc_op1 = 0; acc_crn = 4'd12; acc_crm = 0; acc_op2 = 3'd1;
    acc_wdata = 0; ns_state = 0; priv = 1; wr_lock = 0;
    exc_valid = 0; exc_type = 0; route_irq = 0; route_fiq = 0; route_abt = 0;
  endtask

  // Reference model: compute expectations from requirements, clock once, compare.
  task automatic tick(input string tag);
    logic hit, legal, e_undef, e_rv, routed;
    logic [31:0] e_rd, e_tgt, off;
    hit   = acc_valid && acc_op1 == 0 && acc_crn == 12 && acc_crm == 0 && acc_op2 == 1;
    legal = !ns_state && priv && !(acc_write && wr_lock);
    e_undef = hit && !legal;
    e_rv    = hit && legal && !acc_write;
    e_rd    = e_rv ? ref_base : 32'h0;
    case (exc_type)
      3'd0: begin routed = 1;         off = 32'h08; end
      3'd1: begin routed = route_abt; off = 32'h0C; end
      3'd2: begin routed = route_abt; off = 32'h10; end
      3'd3: begin routed = route_irq; off = 32'h18; end
      3'd4: begin routed = route_fiq; off = 32'h1C; end
      default: begin routed = 0;      off = 32'h00; end
    endcase
    routed = routed && exc_valid;
    e_tgt  = routed ? ref_base + off : 32'h0;
    if (hit && legal && acc_write) ref_base = acc_wdata & 32'hFFFF_FFE0;
    @(posedge clk);
    #2;
    chk(tag, "rd_valid", {31'b0, rd_valid}, {31'b0, e_rv});
    chk(tag, "rd_data", rd_data, e_rd);
    chk(tag, "undef_flag", {31'b0, undef_flag}, {31'b0, e_undef});
    chk(tag, "tgt_valid", {31'b0, tgt_valid}, {31'b0, routed});
    chk(tag, "tgt_addr", tgt_addr, e_tgt);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic acc(input logic wr, input logic [31:0] d, input logic ns, input logic pv, input logic lk);
    acc_valid = 1; acc_write = wr; acc_wdata = d; ns_state = ns; priv = pv; wr_lock = lk;
  endtask

  task automatic exc(input logic [2:0] t, input logic ri, input logic rf, input logic ra);
    exc_valid = 1; exc_type = t; route_irq = ri; route_fiq = rf; route_abt = ra;
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "rd_valid", {31'b0, rd_valid}, 32'h0);
    chk("R1", "undef_flag", {31'b0, undef_flag}, 32'h0);
    chk("R1", "tgt_valid", {31'b0, tgt_valid}, 32'h0);
    chk("R1", "tgt_addr", tgt_addr, 32'h0);
    acc(0, 0, 0, 1, 0); tick("R1");
    // R4 write with low bits set, R3 read back
    acc(1, 32'hDEAD_BEEF, 0, 1, 0); tick("R4");
    acc(0, 0, 0, 1, 0); tick("R3");
    tick("R3");
    // R9 / R10 exceptions with routes off then on
    for (int t = 0; t < 8; t++) begin exc(t[2:0], 0, 0, 0); tick("R10"); end
    for (int t = 0; t < 8; t++) begin exc(t[2:0], 1, 1, 1); tick("R9"); end
    exc(3'd3, 0, 1, 1); tick("R10");
    exc(3'd4, 1, 0, 1); tick("R10");
    exc(3'd1, 1, 1, 0); tick("R10");
    // R2 wrong encodings
    acc(1, 32'h1111_1100, 0, 1, 0); acc_op1 = 3'd1; tick("R2");
    acc(1, 32'h2222_2200, 0, 1, 0); acc_crn = 4'd11; tick("R2");
    acc(1, 32'h3333_3300, 0, 1, 0); acc_crm = 4'd1; tick("R2");
    acc(1, 32'h4444_4400, 0, 1, 0); acc_op2 = 3'd0; tick("R2");
    acc(0, 0, 1, 0, 0); acc_op2 = 3'd2; tick("R2");
    acc(0, 0, 0, 1, 0); tick("R2");
    // R5 non-secure privileged
    acc(1, 32'h5555_5500, 1, 1, 0); tick("R5");
    acc(0, 0, 1, 1, 0); tick("R5");
    // R6 user level in both worlds
    acc(1, 32'h6666_6600, 0, 0, 0); tick("R6");
    acc(1, 32'h6666_6600, 1, 0, 0); tick("R6");
    acc(0, 0, 0, 0, 0); tick("R6");
    acc(0, 0, 0, 1, 0); tick("R6");
    // R7 lock blocks writes, not reads
    acc(1, 32'h7777_7700, 0, 1, 1); tick("R7");
    acc(0, 0, 0, 1, 1); tick("R7");
    // R8 pulse per strobe, back to back then idle
    acc(1, 32'h8888_8800, 1, 1, 0); tick("R8");
    acc(1, 32'h8888_8800, 0, 1, 1); tick("R8");
    tick("R8");
    acc(0, 0, 0, 1, 0); tick("R8");
    // R11 write and exception in same cycle
    acc(1, 32'hA000_0040, 0, 1, 0); exc(3'd0, 0, 0, 0); tick("R11");
    exc(3'd0, 0, 0, 0); tick("R11");
    acc(1, 32'hB000_0000, 0, 1, 0); exc(3'd4, 0, 1, 0); tick("R11");
    exc(3'd2, 0, 0, 1); tick("R11");
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      acc_valid = lf[0]; acc_write = lf[1]; ns_state = lf[2]; priv = lf[3] | lf[4];
      wr_lock = lf[5] & lf[6]; acc_wdata = {lf[15:0], lf[31:16]};
      if (lf[7] & lf[8]) acc_crm = 4'(lf[10:9]);
      exc_valid = lf[11]; exc_type = lf[14:12];
      route_irq = lf[15]; route_fiq = lf[16]; route_abt = lf[17];
      tick("R9");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule